// File: doc/BRIEF.md
# Two-Group Keypad Scan Register

This block is a byte-wide, memory-mapped register that lets a processor read eight push buttons wired as two groups of four. One group holds the action keys (A, B, Select, Start) and the other holds the direction pad (Right, Left, Up, Down). Software writes two active-low group-enable bits to pick the action group, the direction group, both groups or neither. It then reads a four-bit status nibble in which a pressed key shows as 0.

The raw button levels are high while a key is held. They pass through a two-flop synchroniser before they reach the read path. Every register is reset asynchronously by an active-low reset, and that reset is released in step with the clock.

After a group-enable write, the nibble keeps showing the previously enabled groups for one clock. The new selection shows from the cycle after that. The block raises an interrupt request for one clock whenever a bit of the visible nibble drops from 1 to 0.

Top module: `keypad_select_reg`

## Requirements
- R1: After reset the register reads 0xFF and the interrupt request is low.
- R2: Read bits 7 and 6 are always 1. Read bits 5 and 4 return the last written bit 5 (action enable) and bit 4 (direction enable), starting in the cycle after the write.
- R3: With bit 5 = 0 and bit 4 = 1, nibble bit 3/2/1/0 reads 0 exactly when Start/Select/B/A is pressed.
- R4: With bit 5 = 1 and bit 4 = 0, nibble bit 3/2/1/0 reads 0 exactly when Down/Up/Left/Right is pressed.
- R5: With bits 5:4 = 11 the nibble reads 0xF whatever keys are held.
- R6: With bits 5:4 = 00 a nibble bit reads 0 when the key at that position is pressed in either group.
- R7: Written bits 7:6 and 3:0 have no effect on any read bit.
- R8: In the cycle right after a group-enable write, the nibble still reflects the previous enables. It reflects the new enables one cycle later.
- R9: A change on a raw key input reaches the nibble after exactly two clock edges.
- R10: The interrupt request is high for exactly the cycles in which some nibble bit reads 0 after reading 1 in the previous cycle. Releases and presses in a group that is not enabled raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_act_i | input | 4 | Raw action keys, high = pressed: [3] Start, [2] Select, [1] B, [0] A |
| key_dir_i | input | 4 | Raw direction keys, high = pressed: [3] Down, [2] Up, [1] Left, [0] Right |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Write data; only bits 5:4 are stored |
| bus_rdata_o | output | 8 | Read data: 11, enables, active-low nibble |
| irq_o | output | 1 | One-cycle request on a falling nibble bit |

## Verification
The bench holds key patterns that differ between the two groups: action 0101 against direction 1010, so that reading the wrong group or merging the groups wrongly gives a different nibble. It also uses overlapping patterns to test the merge when both groups are enabled. Each of the four enable codes is tried with keys held. Write data carrying ones and zeros in the unused bits separates a correct store from one that keeps bits 7:6 or 3:0. Reads in the cycle right after each write separate the one-cycle settling lag from immediate or late switching. Single-key presses and releases in the enabled and disabled groups show how many synchroniser stages there are and which edge direction raises the request.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_GROUP_W = 4;
  localparam int KP_BUS_W   = 8;
  localparam int KP_SYNC_N  = 2;
  localparam int KP_DIR_BIT = 4;
  localparam int KP_ACT_BIT = 5;
  localparam int KP_PAD_W   = KP_BUS_W - KP_ACT_BIT - 1;

  typedef struct packed {
    logic act_n;
    logic dir_n;
  } kp_sel_t;

  localparam kp_sel_t KP_SEL_NONE = '{act_n: 1'b1, dir_n: 1'b1};
endpackage

// File: rtl/kp_rst_sync.sv
module kp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_d[g] = raw_i;
      end else begin : g_next
        assign stage_d[g] = stage_q[g-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kp_select.sv
module kp_select
  import kp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  kp_sel_t wr_sel_i,
  output kp_sel_t sel_o,
  output kp_sel_t sel_eff_o
);
  kp_sel_t sel_q, sel_d;
  kp_sel_t eff_q, eff_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en_i) sel_d = wr_sel_i;
    eff_d = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= KP_SEL_NONE;
      eff_q <= KP_SEL_NONE;
    end else begin
      sel_q <= sel_d;
      eff_q <= eff_d;
    end
  end

  assign sel_o     = sel_q;
  assign sel_eff_o = eff_q;
endmodule

// File: rtl/kp_merge.sv
module kp_merge
  import kp_pkg::*;
#(
  parameter int GW = KP_GROUP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  kp_sel_t       sel_eff_i,
  input  logic [GW-1:0] act_i,
  input  logic [GW-1:0] dir_i,
  output logic [GW-1:0] nib_no,
  output logic          irq_o
);
  logic [GW-1:0] act_vis;
  logic [GW-1:0] dir_vis;
  logic [GW-1:0] nib_n;
  logic [GW-1:0] last_q, last_d;

  genvar b;
  generate
    for (b = 0; b < GW; b++) begin : g_bit
      assign act_vis[b] = act_i[b] & ~sel_eff_i.act_n;
      assign dir_vis[b] = dir_i[b] & ~sel_eff_i.dir_n;
      assign nib_n[b]   = ~(act_vis[b] | dir_vis[b]);
    end
  endgenerate

  always_comb begin
    last_d = nib_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '1;
    else         last_q <= last_d;
  end

  assign nib_no = nib_n;
  assign irq_o  = |(last_q & ~nib_n);
endmodule

// File: rtl/keypad_select_reg.sv
module keypad_select_reg
  import kp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [KP_GROUP_W-1:0] key_act_i,
  input  logic [KP_GROUP_W-1:0] key_dir_i,
  input  logic                  bus_we_i,
  input  logic [KP_BUS_W-1:0]   bus_wdata_i,
  output logic [KP_BUS_W-1:0]   bus_rdata_o,
  output logic                  irq_o
);
  localparam int RawW = 2 * KP_GROUP_W;

  logic            rst_int_n;
  logic [RawW-1:0] keys_sync;
  kp_sel_t         wr_sel;
  kp_sel_t         sel_cur;
  kp_sel_t         sel_eff;
  logic [KP_GROUP_W-1:0] nib_n;
  logic            unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[KP_BUS_W-1:KP_ACT_BIT+1],
                          bus_wdata_i[KP_DIR_BIT-1:0]};

  kp_rst_sync #(.STAGES(KP_SYNC_N)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  kp_sync #(.WIDTH(RawW), .STAGES(KP_SYNC_N)) i_key_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .raw_i  ({key_act_i, key_dir_i}),
    .sync_o (keys_sync)
  );

  assign wr_sel.act_n = bus_wdata_i[KP_ACT_BIT];
  assign wr_sel.dir_n = bus_wdata_i[KP_DIR_BIT];

  kp_select i_select (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .wr_en_i   (bus_we_i),
    .wr_sel_i  (wr_sel),
    .sel_o     (sel_cur),
    .sel_eff_o (sel_eff)
  );

  kp_merge #(.GW(KP_GROUP_W)) i_merge (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .sel_eff_i (sel_eff),
    .act_i     (keys_sync[RawW-1:KP_GROUP_W]),
    .dir_i     (keys_sync[KP_GROUP_W-1:0]),
    .nib_no    (nib_n),
    .irq_o     (irq_o)
  );

  assign bus_rdata_o = {{KP_PAD_W{1'b1}}, sel_cur.act_n, sel_cur.dir_n, nib_n};
endmodule

// File: rtl/kp_select_reg_chk.sv
module kp_select_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_we_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic       irq_o
);
  AST_PAD_BITS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[7:6] == 2'b11); // R2

  AST_SEL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> bus_rdata_o[5:4] == $past(bus_wdata_i[5:4])); // R2

  AST_NONE_READS_F: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o[5:4] == 2'b11 && $past(bus_rdata_o[5:4]) == 2'b11)
      |-> bus_rdata_o[3:0] == 4'hF); // R5

  AST_IRQ_NEEDS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (($past(bus_rdata_o[3:0]) & ~bus_rdata_o[3:0]) != 4'h0)); // R10

  AST_NONE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o[5:4] == 2'b11 && $past(bus_rdata_o[5:4]) == 2'b11 &&
     $past(bus_rdata_o[5:4], 2) == 2'b11) |-> !irq_o); // R10
endmodule

bind keypad_select_reg kp_select_reg_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/test_keypad_select_reg.sv
module test_keypad_select_reg;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] act, dir;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit run_chk = 1'b0;
  bit done    = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_select_reg i_keypad_select_reg (
    .clk_i(clk), .rst_ni(rst_n), .key_act_i(act), .key_dir_i(dir),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0] m_pipe[$];
  logic [1:0] m_sel, m_eff;
  logic [3:0] m_last;
  int         m_rel;

  function automatic logic [3:0] vis_nib(logic [1:0] eff, logic [7:0] keys);
    logic [3:0] pressed;
    pressed = 4'h0;
    if (!eff[1]) pressed = pressed | keys[7:4];
    if (!eff[0]) pressed = pressed | keys[3:0];
    return ~pressed;
  endfunction

  task automatic model_reset();
    m_pipe.delete();
    m_pipe.push_back(8'h00);
    m_pipe.push_back(8'h00);
    m_sel  = 2'b11;
    m_eff  = 2'b11;
    m_last = 4'hF;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0;
      model_reset();
    end else if (m_rel < 2) begin
      m_rel++;
      model_reset();
    end else begin
      m_last = vis_nib(m_eff, m_pipe[0]);
      m_eff  = m_sel;
      if (we) m_sel = wdata[5:4];
      m_pipe.push_back({act, dir});
      void'(m_pipe.pop_front());
    end
  end

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got rdata/irq %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      logic [3:0] n;
      n = vis_nib(m_eff, m_pipe[0]);
      chk(phase, {rdata, irq}, {2'b11, m_sel, n, |(m_last & ~n)});
    end
  end

  task automatic write_sel(logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; wdata = 8'hA5;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; act = 4'h0; dir = 4'h0; we = 1'b0; wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    run_chk = 1'b1;
    chk("R1", {rdata, irq}, {8'hFF, 1'b0});

    phase = "R5";
    act = 4'b0101; dir = 4'b1010;
    tick(3);
    chk("R5", {rdata, irq}, {8'hFF, 1'b0});

    phase = "R3";
    write_sel(8'h10);                       // bits 7:6 = 00, low = 0 (R7)
    chk("R8", {rdata, irq}, {8'hDF, 1'b0});
    tick(1);
    chk("R3", {rdata, irq}, {8'hDA, 1'b1});
    chk("R7", {1'b0, rdata}, {1'b0, 8'hDA});
    tick(1);
    chk("R10", {rdata, irq}, {8'hDA, 1'b0});

    phase = "R4";
    write_sel(8'hEF);                       // bits 7:6 = 11, low = F (R7)
    chk("R8", {rdata, irq}, {8'hEA, 1'b0});
    tick(1);
    chk("R4", {rdata, irq}, {8'hE5, 1'b1});
    tick(1);

    phase = "R6";
    write_sel(8'h0F);
    chk("R8", {rdata, irq}, {8'hC5, 1'b0});
    tick(1);
    chk("R6", {rdata, irq}, {8'hC0, 1'b1});
    act = 4'b0001; dir = 4'b0011;
    tick(2);
    chk("R6", {rdata, irq}, {8'hCC, 1'b0});
    act = 4'b0100; dir = 4'b0000;
    tick(2);
    chk("R10", {rdata, irq}, {8'hCB, 1'b1});

    phase = "R5";
    write_sel(8'h30);
    chk("R8", {rdata, irq}, {8'hFB, 1'b0});
    tick(1);
    chk("R5", {rdata, irq}, {8'hFF, 1'b0});
    act = 4'hF; dir = 4'hF;
    tick(3);
    chk("R5", {rdata, irq}, {8'hFF, 1'b0});

    phase = "R9";
    act = 4'h0; dir = 4'h0;
    write_sel(8'h10);
    tick(3);
    act = 4'b1000;
    tick(1);
    chk("R9", {rdata, irq}, {8'hDF, 1'b0});
    tick(1);
    chk("R9", {rdata, irq}, {8'hD7, 1'b1});
    tick(1);
    chk("R10", {rdata, irq}, {8'hD7, 1'b0});
    dir = 4'hF;                              // unselected group
    tick(3);
    chk("R10", {rdata, irq}, {8'hD7, 1'b0});
    act = 4'h0;
    tick(2);
    chk("R10", {rdata, irq}, {8'hDF, 1'b0});
    tick(2);

    run_chk = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule